// File: doc/BRIEF.md
# Boot-Phase Command Frame Detector

This block watches a one-bit command line that the host drives alongside its own clock during an early boot handshake. For long stretches the line simply sits high while the clock keeps running. When the host finally talks, it sends a 48-bit command frame that always opens with a low bit. The detector finds that low bit, collects the whole frame most significant bit first, and compares all 48 bits, checksum included, against three fixed boot-phase commands. There are three known commands: return to idle, pre-idle, and start boot transfer. Any other complete frame is reported as an error.

The result is a single-cycle strobe with a 2-bit code. Downstream logic can use the strobe to start or abort a boot data stream. The output has no ready input. The host clock cannot be paused on the detector's behalf, so a consumer must accept each strobe in the cycle it appears. An enable input parks the detector in its hunting state and discards any partly received frame.

Top module: `emmc_boot_cmd_detect`

## Requirements
- R1: After reset, and for any number of cycles in which the command line stays high, `cmd_valid` stays low.
- R2: While hunting, the first sampled 0 on `cmd_line` becomes bit 47 of a frame. The next 47 sampled bits fill bits 46 down to 0, in that order. A frame that begins 0,0 is still collected and classified.
- R3: The frame 0x400000000095 produces code 2'b00.
- R4: The frame 0x40F0F0F0F0FD produces code 2'b01.
- R5: The frame 0x40FFFFFFFAE5 produces code 2'b10.
- R6: Any complete frame that is not one of the three above, including one that differs from them by a single bit, produces code 2'b11.
- R7: `cmd_valid` is high for exactly one cycle per frame. It rises on the rising edge after the edge that sampled the frame's 48th bit, and `cmd_code` is meaningful only while `cmd_valid` is high.
- R8: Hunting resumes on the edge right after the 48th bit is sampled, so a frame that follows with no idle bits in between is still detected.
- R9: While `enable` is low, bits are ignored, no strobe is produced, and a frame in progress is dropped. After enable returns, only a fresh 0 begins a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-driven clock; `cmd_line` is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Detector runs while high; held in hunt while low |
| cmd_line | input | 1 | Serial command line, idles high |
| cmd_valid | output | 1 | One-cycle strobe marking a classified frame |
| cmd_code | output | 2 | 00 idle, 01 pre-idle, 10 boot, 11 error |

## Verification
The serious internal faults are a bit counter that is off by one or a hunt state that is not restored. A miscounted frame boundary shifts every captured bit. The three known frames then turn into error codes, or the strobe appears a cycle early or late at the first frame. A hunt state left active after a frame or after enable drops shows up as a spurious error strobe about 48 cycles later, even when the line is idle. A behavioural model therefore compares the strobe and code on every clock, so any such fault is caught at the first cycle where it diverges.

// File: rtl/emmc_boot_pkg.sv
package emmc_boot_pkg;

  localparam int FRAME_W = 48;
  localparam int N_PAT   = 3;

  typedef enum logic [1:0] {
    CMD_IDLE    = 2'b00,
    CMD_PREIDLE = 2'b01,
    CMD_BOOT    = 2'b10,
    CMD_ERROR   = 2'b11
  } boot_cmd_e;

  // Index in this table is the reported code.
  localparam logic [FRAME_W-1:0] PATTERNS [N_PAT] = '{
    48'h400000000095,
    48'h40F0F0F0F0FD,
    48'h40FFFFFFFAE5
  };

endpackage

// File: rtl/emmc_frame_capture.sv
module emmc_frame_capture #(
  parameter int FRAME_W = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               cmd_line,
  output logic               frame_done,
  output logic [FRAME_W-1:0] frame,
  output logic               busy
);

  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

  typedef enum logic {ST_HUNT, ST_GRAB} cap_state_e;

  cap_state_e       state;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      bit_cnt    <= '0;
      shreg      <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (!enable) begin
        state   <= ST_HUNT;
        bit_cnt <= '0;
      end else begin
        case (state)
          ST_HUNT: begin
            if (!cmd_line) begin
              shreg   <= {shreg[FRAME_W-2:0], 1'b0};
              bit_cnt <= CNT_W'(1);
              state   <= ST_GRAB;
            end
          end
          default: begin
            shreg <= {shreg[FRAME_W-2:0], cmd_line};
            if (bit_cnt == LAST_IDX) begin
              frame_done <= 1'b1;
              bit_cnt    <= '0;
              state      <= ST_HUNT;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign frame = shreg;
  assign busy  = (state == ST_GRAB);

  // A frame completes only from the collecting state.
  assert_done_from_grab_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(busy));

  // The opening bit of every finished frame is the 0 that started it.
  assert_start_bit_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !frame[FRAME_W-1]);

  // Disabling forces the hunt state on the next edge.
  assert_disable_hunts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy && !frame_done);

  // Counter never runs past the last bit index.
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST_IDX);

endmodule

// File: rtl/emmc_frame_classify.sv
module emmc_frame_classify
  import emmc_boot_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  output boot_cmd_e          code
);

  logic [N_PAT-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_PAT; gi++) begin : g_match
      assign hit[gi] = (frame == PATTERNS[gi]);
    end
  endgenerate

  always_comb begin
    code = CMD_ERROR;
    for (int i = N_PAT - 1; i >= 0; i--) begin
      if (hit[i]) code = boot_cmd_e'(2'(i));
    end
  end

  // The fixed patterns are distinct, so at most one comparator fires.
  always_comb begin
    assert_unique_match_R6: assert ($onehot0(hit));
  end

endmodule

// File: rtl/emmc_boot_cmd_detect.sv
module emmc_boot_cmd_detect
  import emmc_boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       cmd_line,
  output logic       cmd_valid,
  output logic [1:0] cmd_code
);

  logic               frame_done;
  logic [FRAME_W-1:0] frame;
  logic               cap_busy;
  boot_cmd_e          class_code;

  emmc_frame_capture #(.FRAME_W(FRAME_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cmd_line   (cmd_line),
    .frame_done (frame_done),
    .frame      (frame),
    .busy       (cap_busy)
  );

  emmc_frame_classify u_classify (
    .frame (frame),
    .code  (class_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_code  <= CMD_IDLE;
    end else begin
      cmd_valid <= frame_done && enable;
      if (frame_done) cmd_code <= class_code;
    end
  end

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  assert_strobe_follows_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(frame_done));

  assert_no_strobe_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(enable));

  assert_idle_during_grab_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !cap_busy);

endmodule

// File: tb/emmc_boot_cmd_detect_tb.sv
module emmc_boot_cmd_detect_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       cmd_line = 1'b1;
  logic       cmd_valid;
  logic [1:0] cmd_code;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int seen [4];

  always #10 clk = ~clk;

  emmc_boot_cmd_detect u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cmd_line(cmd_line),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  // Behavioural reference model
  bit          m_hunt = 1;
  int          m_cnt = 0;
  logic [47:0] m_val = '0;
  bit          m_pend = 0;
  int          m_pcode = 0;
  bit          e_valid = 0;
  int          e_code = 0;

  function automatic int ref_class(logic [47:0] f);
    if (f == 48'h400000000095) return 0;
    if (f == 48'h40F0F0F0F0FD) return 1;
    if (f == 48'h40FFFFFFFAE5) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hunt = 1; m_cnt = 0; m_pend = 0; e_valid = 0;
    end else begin
      e_valid = m_pend && enable;
      if (m_pend) e_code = m_pcode;
      m_pend = 0;
      if (!enable) begin
        m_hunt = 1; m_cnt = 0;
      end else if (m_hunt) begin
        if (!cmd_line) begin m_hunt = 0; m_val = '0; m_cnt = 1; end
      end else begin
        m_val = {m_val[46:0], cmd_line};
        m_cnt++;
        if (m_cnt == 48) begin
          m_pend = 1; m_pcode = ref_class(m_val); m_hunt = 1; m_cnt = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic string code_req(int c);
    case (c)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(cmd_valid == e_valid, "R7 strobe", int'(cmd_valid), int'(e_valid));
      if (e_valid) begin
        chk(int'(cmd_code) == e_code, code_req(e_code), int'(cmd_code), e_code);
        seen[e_code]++;
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_line = 1'b1;
    end
  endtask

  task automatic send(input logic [47:0] f, input int gap);
    for (int i = 47; i >= 0; i--) begin
      @(negedge clk);
      cmd_line = f[i];
    end
    idle(gap);
  endtask

  task automatic clear_seen();
    for (int i = 0; i < 4; i++) seen[i] = 0;
  endtask

  task automatic chk_counts(input string req, input int c0, input int c1,
                            input int c2, input int c3);
    chk(seen[0] == c0, {req, " idle count"}, seen[0], c0);
    chk(seen[1] == c1, {req, " pre-idle count"}, seen[1], c1);
    chk(seen[2] == c2, {req, " boot count"}, seen[2], c2);
    chk(seen[3] == c3, {req, " error count"}, seen[3], c3);
  endtask

  initial begin
    clear_seen();
    repeat (3) @(negedge clk);
    chk(cmd_valid == 1'b0, "R1 reset valid", int'(cmd_valid), 0);
    rst_n = 1'b1;
    enable = 1'b1;

    // R1: long idle high
    idle(300);
    chk_counts("R1", 0, 0, 0, 0);

    // R3, R4, R5 and R2 alignment with odd gaps
    clear_seen();
    send(48'h400000000095, 7);
    send(48'h40F0F0F0F0FD, 13);
    send(48'h40FFFFFFFAE5, 3);
    chk_counts("R3 R4 R5", 1, 1, 1, 0);

    // R6: unknown frame and near-miss
    clear_seen();
    send(48'h4012345678AB, 5);
    send(48'h40FFFFFFFAE4, 5);
    chk_counts("R6", 0, 0, 0, 2);

    // R2: frame opening 0,0 is still collected (classified as error)
    clear_seen();
    send(48'h000000000000, 4);
    chk_counts("R2", 0, 0, 0, 1);

    // R8: back-to-back frames with no idle gap
    clear_seen();
    send(48'h40FFFFFFFAE5, 0);
    send(48'h400000000095, 0);
    send(48'h40F0F0F0F0FD, 4);
    chk_counts("R8", 1, 1, 1, 0);

    // R9: whole frame while disabled
    clear_seen();
    enable = 1'b0;
    send(48'h40FFFFFFFAE5, 5);
    @(negedge clk);
    enable = 1'b1;
    idle(80);
    chk_counts("R9 disabled frame", 0, 0, 0, 0);

    // R9: enable dropped mid-frame, partial frame discarded
    clear_seen();
    for (int i = 47; i >= 28; i--) begin
      @(negedge clk);
      cmd_line = 48'h40FFFFFFFAE5 >> i;
    end
    @(negedge clk);
    enable = 1'b0;
    cmd_line = 1'b1;
    idle(60);
    enable = 1'b1;
    idle(80);
    chk_counts("R9 aborted frame", 0, 0, 0, 0);

    // R9 then R5: detector works again after re-enable
    clear_seen();
    send(48'h40FFFFFFFAE5, 5);
    chk_counts("R9 resume", 0, 0, 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule